// File: doc/BRIEF.md
# Layer Weight Cache

This block keeps on chip the convolution filter words of only the layer being computed. The filters of every other layer stay in external memory. When a new layer begins, a command gives the layer's input channel count, the number of filter taps (width times height) and the bits per tap. The block then takes a stream of bus beats and packs them into one cache word per input channel. Once every word is in, the datapath reads words by channel index through a request port.

Storage is sized for the largest single layer: depth `CH_MAX` words of `TAP_MAX*WB_MAX` bits. It is not sized for the whole network. Each layer word needs `ceil(taps*wbits/BUS_W)` beats. Beats fill a word from bit 0 upward, and the bits of the final beat that lie past the word's length are dropped. The load stream is valid/ready and the source may stall at will. `ld_ready` is high only while a load is in progress. The read request is valid/ready, and `rd_ready` stays low until the layer is fully loaded. The response has a fixed latency and no back-pressure: `rsp_valid` pulses one cycle after each accepted request.

The command must give 1 to `CH_MAX` channels. Read requests must name a channel below the layer's channel count. A beat offered in the same cycle as `cmd_start` is taken but discarded, because the new load starts from scratch.

Top module: `wcache_layer_store`

## Requirements
- R1: Out of reset, `cfg_ready`, `ld_ready`, `rd_ready`, `rsp_valid` and `load_err` are all 0.
- R2: In the cycle after `cmd_start`, `cfg_ready` and `load_err` are 0 and `ld_ready` is 1. A new command made during a load or after a load restarts the load from word 0.
- R3: Channel word j is built from beats j*N to j*N+N-1, where N = ceil(taps*wbits/BUS_W). Beat k of a word occupies bits [16k+15:16k] for BUS_W=16, and it is written at address j.
- R4: Bits of a stored word at and above taps*wbits read back as 0.
- R5: `cfg_ready` rises in the cycle after the final beat of the final word is accepted. With no source stalls this is 1 + Ch*N cycles after the `cmd_start` cycle.
- R6: While `cfg_ready` is 0, `rd_ready` is 0, a read request is not accepted and it produces no response.
- R7: An accepted read of channel c gives `rsp_valid`=1 in the next cycle with the stored word of channel c on `rsp_data`. `rsp_valid` is 0 in every other cycle.
- R8: If `ld_last` arrives on a beat that is not the final beat of the layer, `load_err` becomes 1 and the load is abandoned. `ld_ready` and `cfg_ready` then stay 0 until the next command.
- R9: If the final beat of the layer arrives without `ld_last`, `load_err` becomes 1 and `cfg_ready` still becomes 1.
- R10: After a new layer is loaded, reads return the new layer's words and no longer the previous layer's.
- R11: Cycles with `ld_valid`=0 do not advance the packing; a stalled stream yields the same words as an unstalled one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start loading a new layer (one-cycle pulse) |
| cmd_ch | input | $clog2(CH_MAX+1) | Layer input channel count |
| cmd_taps | input | $clog2(TAP_MAX+1) | Filter taps per channel (width times height) |
| cmd_wbits | input | $clog2(WB_MAX+1) | Bits per filter tap |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Block accepts load beats |
| ld_data | input | BUS_W | Load beat data |
| ld_last | input | 1 | Marks the final beat of the layer |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_ch | input | $clog2(CH_MAX) | Channel index to read |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | TAP_MAX*WB_MAX | Filter word of the requested channel |
| cfg_ready | output | 1 | Current layer fully loaded |
| load_err | output | 1 | Load stream length mismatch |

## Verification
Assertions check several properties on every cycle. A command always drops readiness and clears the error bit. Each accepted read, and only an accepted read, yields a response one cycle later. Readiness rises only right after a word write. Responses carry no bits above the layer's word length. Words are only written below the channel count, and length mismatches raise the error bit with the correct readiness. The exact bit placement of beats in words, the replacement of old layer data, tolerance of source stalls and the load duration all depend on data values and counts. These are shown by the bench's scenarios against its reference model.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
  typedef enum logic [1:0] {
    WC_EMPTY = 2'd0,
    WC_LOAD  = 2'd1,
    WC_READY = 2'd2
  } wc_state_e;
endpackage

// File: rtl/wcache_packer.sv
module wcache_packer #(
  parameter int WORD_W = 72,
  parameter int BUS_W  = 16,
  parameter int LW_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat_fire,
  input  logic [BUS_W-1:0]  beat_data,
  input  logic [LW_W-1:0]   lay_lw,
  output logic              word_done,
  output logic [WORD_W-1:0] word_data
);
  localparam int SPAN  = WORD_W + BUS_W;
  localparam int OFF_W = $clog2(SPAN + 1);

  logic [OFF_W-1:0]  off_q;
  logic [WORD_W-1:0] acc_q;
  logic [SPAN-1:0]   placed;
  logic [SPAN-1:0]   keep_mask;
  logic [WORD_W-1:0] merged;
  logic [OFF_W:0]    off_next;
  logic              fills_word;

  always_comb begin
    placed     = SPAN'(beat_data) << off_q;
    merged     = acc_q | placed[WORD_W-1:0];
    keep_mask  = (SPAN'(1) << lay_lw) - SPAN'(1);
    word_data  = merged & keep_mask[WORD_W-1:0];
    off_next   = {1'b0, off_q} + (OFF_W+1)'(BUS_W);
    fills_word = off_next >= (OFF_W+1)'(lay_lw);
    word_done  = beat_fire & fills_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      off_q <= '0;
      acc_q <= '0;
    end else if (beat_fire) begin
      if (fills_word) begin
        off_q <= '0;
        acc_q <= '0;
      end else begin
        off_q <= off_next[OFF_W-1:0];
        acc_q <= merged;
      end
    end
  end

  AST_OFF_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != '0) |-> ((OFF_W+1)'(off_q) < (OFF_W+1)'(lay_lw))); // R3
endmodule

// File: rtl/wcache_store.sv
module wcache_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 72,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] ent_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_addr == AW'(g)) q <= wr_data;
    end
    assign ent_w[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= ent_w[rd_addr];
  end

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(rd_addr) < DEPTH)); // R7
endmodule

// File: rtl/wcache_layer_store.sv
module wcache_layer_store #(
  parameter int CH_MAX  = 16,
  parameter int TAP_MAX = 9,
  parameter int WB_MAX  = 8,
  parameter int BUS_W   = 16,
  localparam int WORD_W = TAP_MAX * WB_MAX,
  localparam int AW     = $clog2(CH_MAX),
  localparam int CH_W   = $clog2(CH_MAX + 1),
  localparam int TAP_W  = $clog2(TAP_MAX + 1),
  localparam int WB_W   = $clog2(WB_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [CH_W-1:0]   cmd_ch,
  input  logic [TAP_W-1:0]  cmd_taps,
  input  logic [WB_W-1:0]   cmd_wbits,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [BUS_W-1:0]  ld_data,
  input  logic              ld_last,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [AW-1:0]     rd_ch,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              cfg_ready,
  output logic              load_err
);
  import wcache_pkg::*;
  localparam int LW_W = $clog2(WORD_W + 1);

  wc_state_e         st_q;
  logic [CH_W-1:0]   lay_ch_q;
  logic [LW_W-1:0]   lay_lw_q;
  logic [AW-1:0]     wptr_q;
  logic              err_q;
  logic              rsp_v_q;
  logic [TAP_W+WB_W-1:0] cmd_prod;
  logic              beat_fire;
  logic              word_done;
  logic [WORD_W-1:0] word_data;
  logic              last_word;
  logic              rd_fire;

  assign cmd_prod  = cmd_taps * cmd_wbits;
  assign ld_ready  = (st_q == WC_LOAD);
  assign cfg_ready = (st_q == WC_READY);
  assign rd_ready  = cfg_ready;
  assign load_err  = err_q;
  assign rsp_valid = rsp_v_q;
  assign beat_fire = ld_valid & ld_ready & ~cmd_start;
  assign rd_fire   = rd_valid & rd_ready;
  assign last_word = (CH_W'(wptr_q) == lay_ch_q - CH_W'(1));

  wcache_packer #(.WORD_W(WORD_W), .BUS_W(BUS_W), .LW_W(LW_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .clear(cmd_start), .beat_fire(beat_fire),
    .beat_data(ld_data), .lay_lw(lay_lw_q), .word_done(word_done),
    .word_data(word_data));

  wcache_store #(.DEPTH(CH_MAX), .WORD_W(WORD_W), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(word_done), .wr_addr(wptr_q),
    .wr_data(word_data), .rd_en(rd_fire), .rd_addr(rd_ch), .rd_data(rsp_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= WC_EMPTY;
      lay_ch_q <= '0;
      lay_lw_q <= '0;
      wptr_q   <= '0;
      err_q    <= 1'b0;
      rsp_v_q  <= 1'b0;
    end else begin
      rsp_v_q <= rd_fire;
      if (cmd_start) begin
        st_q     <= WC_LOAD;
        lay_ch_q <= cmd_ch;
        lay_lw_q <= LW_W'(cmd_prod);
        wptr_q   <= '0;
        err_q    <= 1'b0;
      end else if (beat_fire) begin
        if (word_done && last_word) begin
          st_q <= WC_READY;
          if (!ld_last) err_q <= 1'b1;
        end else begin
          if (word_done) wptr_q <= wptr_q + AW'(1);
          if (ld_last) begin
            err_q <= 1'b1;
            st_q  <= WC_EMPTY;
          end
        end
      end
    end
  end

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (!cfg_ready && !load_err && ld_ready)); // R2
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid); // R7
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rsp_valid); // R6
  AST_READY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ready) |-> $past(word_done)); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(cmd_start)) |-> ((rsp_data >> lay_lw_q) == '0)); // R4
  AST_WR_WITHIN_LAYER: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (CH_W'(wptr_q) < lay_ch_q)); // R3
  AST_EARLY_LAST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && ld_last && !(word_done && last_word)) |=> (load_err && !cfg_ready && !ld_ready)); // R8
  AST_MISSING_LAST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && last_word && !ld_last) |=> (load_err && cfg_ready)); // R9
endmodule

// File: tb/wcache_layer_store_tb_top.sv
module wcache_layer_store_tb_top;
  localparam int CH_MAX = 16, TAP_MAX = 9, WB_MAX = 8, BUS_W = 16;
  localparam int WORD_W = TAP_MAX * WB_MAX;
  localparam int AW = $clog2(CH_MAX);

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0;
  logic [$clog2(CH_MAX+1)-1:0] cmd_ch = '0;
  logic [$clog2(TAP_MAX+1)-1:0] cmd_taps = '0;
  logic [$clog2(WB_MAX+1)-1:0] cmd_wbits = '0;
  logic ld_valid = 0, ld_last = 0, rd_valid = 0;
  logic [BUS_W-1:0] ld_data = '0;
  logic [AW-1:0] rd_ch = '0;
  logic ld_ready, rd_ready, rsp_valid, cfg_ready, load_err;
  logic [WORD_W-1:0] rsp_data;

  int checks = 0, errors = 0, cyc = 0, t_start = 0;
  bit done = 0;

  wcache_layer_store #(.CH_MAX(CH_MAX), .TAP_MAX(TAP_MAX), .WB_MAX(WB_MAX), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ch(cmd_ch), .cmd_taps(cmd_taps),
    .cmd_wbits(cmd_wbits), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .ld_last(ld_last), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_ch(rd_ch),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_ready(cfg_ready), .load_err(load_err));

  always #5 clk = ~clk;

  task automatic chk(input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: behavioural, updated at each rising edge
  int m_st = 0, m_widx = 0, m_off = 0, m_ch = 0, m_lw = 0;
  bit m_err = 0, m_rspv = 0;
  logic [WORD_W-1:0] m_acc = '0, m_rspd = '0;
  logic [WORD_W-1:0] m_mem [CH_MAX];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_err = 0; m_rspv = 0; m_widx = 0; m_off = 0; m_acc = '0;
      for (int i = 0; i < CH_MAX; i++) m_mem[i] = '0;
    end else begin
      m_rspv = rd_valid && (m_st == 2);
      if (m_rspv) m_rspd = m_mem[rd_ch];
      if (cmd_start) begin
        m_st = 1; m_err = 0; m_widx = 0; m_off = 0; m_acc = '0;
        m_ch = int'(cmd_ch); m_lw = int'(cmd_taps) * int'(cmd_wbits);
      end else if (m_st == 1 && ld_valid) begin
        for (int i = 0; i < BUS_W; i++)
          if (m_off + i < m_lw) m_acc[m_off + i] = ld_data[i];
        if (m_off + BUS_W >= m_lw) begin
          m_mem[m_widx] = m_acc; m_acc = '0; m_off = 0;
          if (m_widx == m_ch - 1) begin
            m_st = 2;
            if (!ld_last) m_err = 1;
          end else begin
            m_widx++;
            if (ld_last) begin m_err = 1; m_st = 0; end
          end
        end else begin
          m_off += BUS_W;
          if (ld_last) begin m_err = 1; m_st = 0; end
        end
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(WORD_W'(cfg_ready), WORD_W'(m_st == 2), "R5 cfg_ready per cycle");
      chk(WORD_W'(ld_ready), WORD_W'(m_st == 1), "R2 ld_ready per cycle");
      chk(WORD_W'(rd_ready), WORD_W'(m_st == 2), "R6 rd_ready per cycle");
      chk(WORD_W'(load_err), WORD_W'(m_err), "R8 load_err per cycle");
      chk(WORD_W'(rsp_valid), WORD_W'(m_rspv), "R7 rsp_valid per cycle");
      if (m_rspv) chk(rsp_data, m_rspd, "R7 rsp_data per cycle");
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  function automatic logic [BUS_W-1:0] beat_val(input int seed, input int idx);
    return BUS_W'(seed * 40503 + idx * 4093 + 23101);
  endfunction

  function automatic logic [WORD_W-1:0] exp_word(input int seed, input int w, input int lw);
    logic [WORD_W-1:0] word = '0;
    int nb = (lw + BUS_W - 1) / BUS_W;
    for (int b = 0; b < nb; b++) word |= WORD_W'(beat_val(seed, w * nb + b)) << (BUS_W * b);
    if (lw < WORD_W) word &= (WORD_W'(1) << lw) - WORD_W'(1);
    return word;
  endfunction

  // tasks enter and return at a falling edge
  task automatic start_layer(input int ch, input int taps, input int wb);
    cmd_start = 1; cmd_ch = ch[$bits(cmd_ch)-1:0];
    cmd_taps = taps[$bits(cmd_taps)-1:0]; cmd_wbits = wb[$bits(cmd_wbits)-1:0];
    t_start = cyc;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic send_beat(input logic [BUS_W-1:0] d, input bit l);
    ld_valid = 1; ld_data = d; ld_last = l;
    while (!ld_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ld_idle();
    ld_valid = 0; ld_last = 0;
  endtask

  task automatic send_layer(input int seed, input int nbeats, input bit stall, input bit mark_last);
    for (int i = 0; i < nbeats; i++) begin
      send_beat(beat_val(seed, i), mark_last && (i == nbeats - 1));
      if (stall) begin ld_idle(); @(negedge clk); end
    end
    ld_idle();
  endtask

  task automatic read_ch(input int c, output logic got_v, output logic [WORD_W-1:0] got_d);
    rd_valid = 1; rd_ch = c[AW-1:0];
    @(negedge clk);
    rd_valid = 0;
    got_v = rsp_valid; got_d = rsp_data;
  endtask

  initial begin
    logic v;
    logic [WORD_W-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(WORD_W'({cfg_ready, ld_ready, rd_ready, rsp_valid, load_err}), '0, "R1 reset outputs");

    // layer A: 4 channels, 9 taps x 8 bits, 5 beats per word, no stalls
    start_layer(4, 9, 8);
    chk(WORD_W'({cfg_ready, load_err, ld_ready}), WORD_W'(3'b001), "R2 after start");
    send_layer(1, 20, 0, 1);
    chk(WORD_W'(cyc - t_start), WORD_W'(21), "R5 load duration");
    chk(WORD_W'({cfg_ready, load_err}), WORD_W'(2'b10), "R5 ready after load");
    for (int c = 0; c < 4; c++) begin
      read_ch(c, v, d);
      chk(WORD_W'(v), WORD_W'(1), "R7 response valid");
      chk(d, exp_word(1, c, 72), "R3 packed word layer A");
    end

    // layer B: 3 channels, 1 tap x 4 bits, read while loading, stalled stream
    start_layer(3, 1, 4);
    read_ch(0, v, d);
    chk(WORD_W'({v, rd_ready}), '0, "R6 read blocked during load");
    send_layer(2, 3, 1, 1);
    chk(WORD_W'(cfg_ready), WORD_W'(1), "R11 stalled load completes");
    for (int c = 0; c < 3; c++) begin
      read_ch(c, v, d);
      chk(d, exp_word(2, c, 4), "R11 stalled word");
      chk(d >> 4, '0, "R4 upper bits zero");
    end

    // early last
    start_layer(2, 4, 8);
    send_layer(3, 3, 0, 1);
    chk(WORD_W'({load_err, cfg_ready, ld_ready}), WORD_W'(3'b100), "R8 early last");
    read_ch(0, v, d);
    chk(WORD_W'(v), '0, "R8 no read after abort");

    // missing last
    start_layer(2, 4, 8);
    send_layer(4, 4, 0, 0);
    chk(WORD_W'({load_err, cfg_ready}), WORD_W'(2'b11), "R9 missing last");
    read_ch(1, v, d);
    chk(d, exp_word(4, 1, 32), "R9 words still stored");

    // reload with layer A shape, new data
    start_layer(4, 9, 8);
    send_layer(5, 20, 1, 1);
    read_ch(0, v, d);
    chk(d, exp_word(5, 0, 72), "R10 new layer word");
    chk(WORD_W'(d != exp_word(1, 0, 72)), WORD_W'(1), "R10 old word replaced");
    read_ch(3, v, d);
    chk(d, exp_word(5, 3, 72), "R10 new layer last channel");

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule